// File: doc/BRIEF.md
# Two-Bus Timing-Step Processor Datapath

This block is a small processor datapath whose work is divided into timing steps, one per clock. It has two internal buses. A source bus carries one value per step from the program counter, the memory buffer or the register file. That bus feeds the B operand of the arithmetic unit. The unit's result drives a destination bus, and every loadable register takes its value from that bus. A holding register keeps operand A. A three-register operation therefore writes its destination in the same step that computes the result, and no result temporary is needed. Moving a value unchanged from one bus to the other uses the unit's pass-through function.

Every instruction starts with three fetch steps. T0 copies the PC into the address register. T1 reads memory into the buffer and writes PC plus four back through the unit. T2 moves the buffer into the instruction register. Add and subtract then take two more steps: T3 copies the first source into the holding register, and T4 computes the result and writes the destination. Any other opcode spends T3 idle and returns to T0. Memory is single-cycle, with an address, a read strobe and a data return. A registered read port lets a test or a neighbour inspect the register file.

Top module: `twobus_core`

## Requirements
- R1: After synchronous reset, the step output reads 0 (T0), the PC reads 0, the memory read strobe is low, and register i holds the value i.
- R2: The memory read strobe is high exactly in step 1 (T1). In that step the memory address equals the address of the instruction being fetched. In every other step the strobe is low.
- R3: The PC holds its value in every step except T1, and it reads the old PC plus 4 from step 2 onward.
- R4: Opcode 14 in instruction bits [31:27] is subtract. It writes register ra = R[rb] - R[rc] modulo 2^32, with ra in bits [26:22], rb in bits [21:17] and rc in bits [16:12].
- R5: Opcode 13 is add. It writes register ra = R[rb] + R[rc] modulo 2^32, using the same field positions as R4.
- R6: Add and subtract each occupy exactly 5 cycles (T0 to T4), after which the step returns to T0 for the next fetch.
- R7: Any other opcode occupies exactly 4 cycles (T0 to T3) and changes no register.
- R8: The result is correct when the destination equals a source, and when both sources name the same register.
- R9: A result written in T4 is the value that the very next instruction reads as a source.
- R10: The register read port returns R[sel] one clock after the select is presented.
- R11: Reset asserted in the middle of an instruction returns the step to T0, the PC to 0 and every register to its reset value. The interrupted write does not happen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | 32 | Memory word address (address register) |
| mem_rd | output | 1 | Memory read strobe |
| mem_rdata | input | 32 | Memory data, valid in the same step as the strobe |
| dbg_sel | input | 5 | Register file inspection select |
| dbg_data | output | 32 | Registered contents of the selected register |
| pc_o | output | 32 | Current program counter |
| step_o | output | 3 | Current timing step, 0 to 4 |

## Verification
The hardest case to reach from the ports is a reset that lands after the holding register has been loaded and before the destination write. The bench places a subtract in memory, watches the step output until it reads 3, and then asserts reset. After reset it confirms through the read port that the destination register kept its reset value. A dependent subtract that directly follows another exercises the write-then-read path between T4 and the next T3. Opcodes outside add and subtract are placed between operations to show the shorter four-step path and that it leaves the registers unchanged.

// File: rtl/twobus_pkg.sv
package twobus_pkg;

  localparam int OPC_W = 5;
  localparam logic [OPC_W-1:0] OPC_ADD = 5'd13;
  localparam logic [OPC_W-1:0] OPC_SUB = 5'd14;

  typedef enum logic [2:0] {
    ST_T0 = 3'd0,
    ST_T1 = 3'd1,
    ST_T2 = 3'd2,
    ST_T3 = 3'd3,
    ST_T4 = 3'd4
  } step_e;

  typedef enum logic [1:0] {
    FN_PASS = 2'd0,
    FN_INC  = 2'd1,
    FN_ADD  = 2'd2,
    FN_SUB  = 2'd3
  } alsu_fn_e;

  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_PC   = 2'd1,
    SRC_MBR  = 2'd2,
    SRC_RF   = 2'd3
  } obus_src_e;

  typedef struct packed {
    obus_src_e src;
    logic      sel_rc;
    alsu_fn_e  fn;
    logic      ld_mar;
    logic      ld_pc;
    logic      ld_mbr;
    logic      ld_ir;
    logic      ld_a;
    logic      ld_rf;
  } ctl_t;

endpackage

// File: rtl/twobus_ctrl.sv
module twobus_ctrl
  import twobus_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [OPC_W-1:0] opcode,
  output step_e            step,
  output step_e            step_nxt,
  output ctl_t             ctl
);

  logic is_add;
  logic is_sub;
  logic is_exec;

  assign is_add  = (opcode == OPC_ADD);
  assign is_sub  = (opcode == OPC_SUB);
  assign is_exec = is_add | is_sub;

  always_comb begin
    case (step)
      ST_T0:   step_nxt = ST_T1;
      ST_T1:   step_nxt = ST_T2;
      ST_T2:   step_nxt = ST_T3;
      ST_T3:   step_nxt = is_exec ? ST_T4 : ST_T0;
      default: step_nxt = ST_T0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) step <= ST_T0;
    else     step <= step_nxt;
  end

  always_comb begin
    ctl = '{src: SRC_NONE, sel_rc: 1'b0, fn: FN_PASS,
            ld_mar: 1'b0, ld_pc: 1'b0, ld_mbr: 1'b0,
            ld_ir: 1'b0, ld_a: 1'b0, ld_rf: 1'b0};
    case (step)
      ST_T0: begin
        ctl.src    = SRC_PC;
        ctl.fn     = FN_PASS;
        ctl.ld_mar = 1'b1;
      end
      ST_T1: begin
        ctl.src    = SRC_PC;
        ctl.fn     = FN_INC;
        ctl.ld_pc  = 1'b1;
        ctl.ld_mbr = 1'b1;
      end
      ST_T2: begin
        ctl.src   = SRC_MBR;
        ctl.fn    = FN_PASS;
        ctl.ld_ir = 1'b1;
      end
      ST_T3: begin
        if (is_exec) begin
          ctl.src    = SRC_RF;
          ctl.sel_rc = 1'b0;
          ctl.fn     = FN_PASS;
          ctl.ld_a   = 1'b1;
        end
      end
      ST_T4: begin
        ctl.src    = SRC_RF;
        ctl.sel_rc = 1'b1;
        ctl.fn     = is_sub ? FN_SUB : FN_ADD;
        ctl.ld_rf  = is_exec;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/twobus_alsu.sv
module twobus_alsu
  import twobus_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int PC_INC = 4
) (
  input  alsu_fn_e          fn,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] c
);

  always_comb begin
    case (fn)
      FN_INC:  c = b + DATA_W'(PC_INC);
      FN_ADD:  c = a + b;
      FN_SUB:  c = a - b;
      default: c = b;
    endcase
  end

endmodule

// File: rtl/twobus_regfile.sv
module twobus_regfile #(
  parameter int DATA_W = 32,
  parameter int NREG   = 32,
  parameter int AW     = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata,
  input  logic [AW-1:0]     dbg_addr,
  output logic [DATA_W-1:0] dbg_data
);

  logic [DATA_W-1:0] regs [NREG];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) regs[i] <= DATA_W'(i);
      dbg_data <= '0;
    end else begin
      if (we) regs[waddr] <= wdata;
      dbg_data <= regs[dbg_addr];
    end
  end

  assign rdata = regs[raddr];

endmodule

// File: rtl/twobus_core.sv
module twobus_core
  import twobus_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int NREG   = 32,
  parameter int PC_INC = 4,
  parameter int RA_LSB = 22,
  parameter int RB_LSB = 17,
  parameter int RC_LSB = 12
) (
  input  logic                    clk,
  input  logic                    rst,
  output logic [DATA_W-1:0]       mem_addr,
  output logic                    mem_rd,
  input  logic [DATA_W-1:0]       mem_rdata,
  input  logic [$clog2(NREG)-1:0] dbg_sel,
  output logic [DATA_W-1:0]       dbg_data,
  output logic [DATA_W-1:0]       pc_o,
  output logic [2:0]              step_o
);

  localparam int AW     = $clog2(NREG);
  localparam int IR_LSB = RC_LSB;

  step_e step;
  step_e step_nxt;
  ctl_t  ctl;

  logic [DATA_W-1:0]      pc_q;
  logic [DATA_W-1:0]      mar_q;
  logic [DATA_W-1:0]      mbr_q;
  logic [DATA_W-1:0]      a_q;
  logic [DATA_W-1:IR_LSB] ir_q;
  logic                   rd_q;

  logic [DATA_W-1:0] obus;
  logic [DATA_W-1:0] ibus;
  logic [DATA_W-1:0] rf_rdata;
  logic [AW-1:0]     rf_raddr;
  logic [AW-1:0]     f_ra;
  logic [AW-1:0]     f_rb;
  logic [AW-1:0]     f_rc;
  logic [OPC_W-1:0]  opcode;

  assign opcode = ir_q[DATA_W-1 -: OPC_W];
  assign f_ra   = ir_q[RA_LSB +: AW];
  assign f_rb   = ir_q[RB_LSB +: AW];
  assign f_rc   = ir_q[RC_LSB +: AW];

  twobus_ctrl ctrl_i (
    .clk      (clk),
    .rst      (rst),
    .opcode   (opcode),
    .step     (step),
    .step_nxt (step_nxt),
    .ctl      (ctl)
  );

  assign rf_raddr = ctl.sel_rc ? f_rc : f_rb;

  twobus_regfile #(.DATA_W(DATA_W), .NREG(NREG), .AW(AW)) rf_i (
    .clk      (clk),
    .rst      (rst),
    .we       (ctl.ld_rf),
    .waddr    (f_ra),
    .wdata    (ibus),
    .raddr    (rf_raddr),
    .rdata    (rf_rdata),
    .dbg_addr (dbg_sel),
    .dbg_data (dbg_data)
  );

  always_comb begin
    case (ctl.src)
      SRC_PC:  obus = pc_q;
      SRC_MBR: obus = mbr_q;
      SRC_RF:  obus = rf_rdata;
      default: obus = '0;
    endcase
  end

  twobus_alsu #(.DATA_W(DATA_W), .PC_INC(PC_INC)) alsu_i (
    .fn (ctl.fn),
    .a  (a_q),
    .b  (obus),
    .c  (ibus)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q  <= '0;
      mar_q <= '0;
      mbr_q <= '0;
      a_q   <= '0;
      ir_q  <= '0;
      rd_q  <= 1'b0;
    end else begin
      if (ctl.ld_mar) mar_q <= ibus;
      if (ctl.ld_pc)  pc_q  <= ibus;
      if (ctl.ld_mbr) mbr_q <= mem_rdata;
      if (ctl.ld_ir)  ir_q  <= ibus[DATA_W-1:IR_LSB];
      if (ctl.ld_a)   a_q   <= ibus;
      rd_q <= (step_nxt == ST_T1);
    end
  end

  assign mem_addr = mar_q;
  assign mem_rd   = rd_q;
  assign pc_o     = pc_q;
  assign step_o   = step;

endmodule

// File: rtl/twobus_core_chk.sv
module twobus_core_chk #(
  parameter int DATA_W = 32,
  parameter int PC_INC = 4
) (
  input logic              clk,
  input logic              rst,
  input logic [2:0]        step_o,
  input logic [DATA_W-1:0] pc_o,
  input logic              mem_rd,
  input logic [DATA_W-1:0] mem_addr
);

  AST_RESET_ENTRY: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (step_o == 3'd0 && pc_o == '0 && !mem_rd)); // R1
  AST_RD_ONLY_T1: assert property (@(posedge clk) disable iff (rst)
    mem_rd == (step_o == 3'd1)); // R2
  AST_ADDR_IS_PC: assert property (@(posedge clk) disable iff (rst)
    (step_o == 3'd1) |-> (mem_addr == pc_o)); // R2
  AST_PC_ADVANCE: assert property (@(posedge clk) disable iff (rst)
    (step_o == 3'd1) |=> (pc_o == $past(pc_o) + DATA_W'(PC_INC))); // R3
  AST_PC_HOLD: assert property (@(posedge clk) disable iff (rst)
    (step_o != 3'd1) |=> $stable(pc_o)); // R3
  AST_STEP_RANGE: assert property (@(posedge clk) disable iff (rst)
    step_o <= 3'd4); // R6
  AST_T0_TO_T1: assert property (@(posedge clk) disable iff (rst)
    (step_o == 3'd0) |=> (step_o == 3'd1)); // R6
  AST_T1_TO_T2: assert property (@(posedge clk) disable iff (rst)
    (step_o == 3'd1) |=> (step_o == 3'd2)); // R6
  AST_T2_TO_T3: assert property (@(posedge clk) disable iff (rst)
    (step_o == 3'd2) |=> (step_o == 3'd3)); // R6
  AST_T4_TO_T0: assert property (@(posedge clk) disable iff (rst)
    (step_o == 3'd4) |=> (step_o == 3'd0)); // R6

endmodule

bind twobus_core twobus_core_chk #(.DATA_W(DATA_W), .PC_INC(PC_INC)) chk_i (
  .clk      (clk),
  .rst      (rst),
  .step_o   (step_o),
  .pc_o     (pc_o),
  .mem_rd   (mem_rd),
  .mem_addr (mem_addr)
);

// File: tb/twobus_core_tb_top.sv
`timescale 1ns/1ps
module twobus_core_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] mem_addr;
  logic        mem_rd;
  logic [31:0] mem_rdata;
  logic [4:0]  dbg_sel = '0;
  logic [31:0] dbg_data;
  logic [31:0] pc_o;
  logic [2:0]  step_o;

  logic [31:0] mem [256];
  logic [31:0] exp_rf [32];
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  assign mem_rdata = mem[mem_addr[9:2]];

  twobus_core dut_i (
    .clk       (clk),
    .rst       (rst),
    .mem_addr  (mem_addr),
    .mem_rd    (mem_rd),
    .mem_rdata (mem_rdata),
    .dbg_sel   (dbg_sel),
    .dbg_data  (dbg_data),
    .pc_o      (pc_o),
    .step_o    (step_o)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 32; i++) exp_rf[i] = 32'(i);
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 256; i++) mem[i] = 32'h0;
  endtask

  task automatic sync_t0();
    @(negedge clk);
    while (step_o != 3'd0) @(negedge clk);
  endtask

  task automatic chk_reg(input int idx, input string req);
    @(negedge clk);
    dbg_sel = 5'(idx);
    @(negedge clk);
    check(dbg_data == exp_rf[idx], req, $sformatf("reg %0d", idx), dbg_data, exp_rf[idx]);
  endtask

  task automatic do_op(input logic [4:0] op, input logic [4:0] ra,
                       input logic [4:0] rb, input logic [4:0] rc);
    logic [31:0] pc0;
    int n;
    int exp_len;
    bit exec;
    sync_t0();
    exec = (op == 5'd13) || (op == 5'd14);
    mem[pc_o[9:2]] = {op, ra, rb, rc, 12'h000};
    pc0 = pc_o;
    n = 0;
    forever begin
      @(negedge clk);
      n++;
      if (step_o == 3'd1) begin
        check(mem_rd == 1'b1, "R2", "strobe in T1", 32'(mem_rd), 32'd1);
        check(mem_addr == pc0, "R2", "fetch address", mem_addr, pc0);
      end else begin
        check(mem_rd == 1'b0, "R2", "strobe outside T1", 32'(mem_rd), 32'd0);
      end
      if (step_o == 3'd2) check(pc_o == pc0 + 32'd4, "R3", "pc advance", pc_o, pc0 + 32'd4);
      if (step_o == 3'd0 || n > 8) break;
    end
    exp_len = exec ? 5 : 4;
    check(n == exp_len, exec ? "R6" : "R7", "instruction length", 32'(n), 32'(exp_len));
    if (op == 5'd14) exp_rf[ra] = exp_rf[rb] - exp_rf[rc];
    if (op == 5'd13) exp_rf[ra] = exp_rf[rb] + exp_rf[rc];
  endtask

  task automatic t_reset();
    check(step_o == 3'd0, "R1", "reset step", 32'(step_o), 32'd0);
    check(pc_o == 32'd0, "R1", "reset pc", pc_o, 32'd0);
    check(mem_rd == 1'b0, "R1", "reset strobe", 32'(mem_rd), 32'd0);
    chk_reg(12, "R1");
    chk_reg(31, "R1");
  endtask

  task automatic t_sub();
    do_op(5'd14, 5'd1, 5'd10, 5'd4);
    chk_reg(1, "R4");
    do_op(5'd14, 5'd2, 5'd4, 5'd10);
    chk_reg(2, "R4");
  endtask

  task automatic t_add();
    do_op(5'd13, 5'd3, 5'd1, 5'd2);
    chk_reg(3, "R5");
    do_op(5'd13, 5'd0, 5'd31, 5'd31);
    chk_reg(0, "R5");
  endtask

  task automatic t_other_ops();
    do_op(5'd0, 5'd5, 5'd6, 5'd7);
    do_op(5'd31, 5'd5, 5'd5, 5'd5);
    do_op(5'd15, 5'd5, 5'd9, 5'd1);
    chk_reg(5, "R7");
  endtask

  task automatic t_alias();
    do_op(5'd14, 5'd7, 5'd7, 5'd7);
    chk_reg(7, "R8");
    do_op(5'd13, 5'd8, 5'd8, 5'd8);
    chk_reg(8, "R8");
  endtask

  task automatic t_chain();
    do_op(5'd14, 5'd9, 5'd1, 5'd8);
    do_op(5'd14, 5'd11, 5'd9, 5'd1);
    chk_reg(11, "R9");
    chk_reg(9, "R9");
  endtask

  task automatic t_dbg();
    @(negedge clk);
    dbg_sel = 5'd20;
    @(negedge clk);
    check(dbg_data == exp_rf[20], "R10", "read port first select", dbg_data, exp_rf[20]);
    dbg_sel = 5'd1;
    check(dbg_data == exp_rf[20], "R10", "read port before edge", dbg_data, exp_rf[20]);
    @(negedge clk);
    check(dbg_data == exp_rf[1], "R10", "read port second select", dbg_data, exp_rf[1]);
  endtask

  task automatic t_midreset();
    sync_t0();
    mem[pc_o[9:2]] = {5'd14, 5'd20, 5'd1, 5'd9, 12'h000};
    while (step_o != 3'd3) @(negedge clk);
    rst = 1'b1;
    clear_mem();
    model_reset();
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    check(step_o == 3'd0, "R11", "step after reset", 32'(step_o), 32'd0);
    check(pc_o == 32'd0, "R11", "pc after reset", pc_o, 32'd0);
    chk_reg(20, "R11");
    chk_reg(1, "R11");
    do_op(5'd14, 5'd4, 5'd20, 5'd1);
    chk_reg(4, "R11");
  endtask

  initial begin
    clear_mem();
    model_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_sub();
    t_add();
    t_other_ops();
    t_alias();
    t_chain();
    t_dbg();
    t_midreset();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule